// File: doc/BRIEF.md
# Vector Unpack-and-Widen Unit

This unit takes one instruction word per cycle, together with the contents of one or two source vector registers, each VL bits wide. Every source element is widened to twice its width. When the extension bit of the word is clear the new upper half copies the element's sign bit. When the bit is set the upper half is filled with zeros.

Each source vector is treated as two halves. The lower half fills one destination register and the upper half fills the next one. One source therefore gives two destination registers, and a pair of sources gives four.

The unit also decodes the instruction word. From it the unit finds the group mode, the element size, the signedness and the register numbers. The source register numbers leave the unit at once, without a register, so that an outside register file can return the source data in the same cycle. The widened results, the write enables, the destination numbers and an undefined-instruction flag are registered and appear one cycle later.

Top module: `vec_unpack_widen`

## Requirements
- R1: The size field `instr[23:22]` sets the destination element width to 8 shifted left by its value: 1 gives 16 bits, 2 gives 32 bits, 3 gives 64 bits. Each source element is half that width.
- R2: A recognised word whose size field is 0 produces `out_valid`=1 and `out_undef`=1 one cycle later, with `out_we`=0 and all data outputs zero.
- R3: In pair mode, element e of destination 0 comes from source element e of `src0`, and element e of destination 1 comes from source element (VL/dest width)+e of `src0`. `out_we` is 4'b0011.
- R4: In quad mode, `src0` fills destinations 0 and 1 and `src1` fills destinations 2 and 3. Each source is split into halves as in R3. `out_we` is 4'b1111.
- R5: In pair mode, `src_idx0` equals `instr[9:5]` and `src_idx1` is 0. Destination k is numbered `instr[4:1]`*2+k.
- R6: In quad mode, `src_idx0` equals `instr[9:6]`*2 and `src_idx1` equals that value plus 1. Destination k is numbered `instr[4:2]`*4+k.
- R7: When `instr[0]` is 0 the upper half of each widened element is a copy of the source sign bit. When `instr[0]` is 1 the upper half is zero.
- R8: A word is recognised only if `instr[31:24]`=8'hC1 and one of two conditions holds. Pair mode needs `instr[21:10]`=12'b100101111000. Quad mode needs `instr[21:10]`=12'b110101111000 with `instr[5]`=0 and `instr[1]`=0. Any other word with `in_valid` produces `out_valid`=0 and `out_we`=0 in the next cycle.
- R9: In pair mode, `out_d2`, `out_d3`, `out_idx2` and `out_idx3` are zero.
- R10: The outputs register the inputs accepted at the previous rising edge. A cycle without `in_valid` leaves `out_valid`, `out_undef` and `out_we` at 0 in the next cycle. A synchronous `rst` clears all registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and sources are present |
| instr | input | 32 | Instruction word |
| src0 | input | VL | Contents of the first source register |
| src1 | input | VL | Contents of the second source register (quad mode only) |
| src_idx0 | output | 5 | First source register number (combinational) |
| src_idx1 | output | 5 | Second source register number (combinational) |
| out_valid | output | 1 | A recognised word was accepted in the previous cycle |
| out_undef | output | 1 | The accepted word has a reserved size |
| out_we | output | 4 | Write enable for each destination |
| out_idx0 | output | 5 | Register number of destination 0 |
| out_idx1 | output | 5 | Register number of destination 1 |
| out_idx2 | output | 5 | Register number of destination 2 |
| out_idx3 | output | 5 | Register number of destination 3 |
| out_d0 | output | VL | Data for destination 0 |
| out_d1 | output | VL | Data for destination 1 |
| out_d2 | output | VL | Data for destination 2 |
| out_d3 | output | VL | Data for destination 3 |

## Verification
In a single cycle, the opcode match can select quad mode while the size check finds the reserved value. Mode decode and undefined detection then act on the same word. The bench provokes this with a quad-mode word whose size field is 0. The check passes only if `out_undef` is raised and every write enable and data output stays at zero, even though quad mode alone would enable all four destinations. A second overlap uses the fixed quad-mode bits: a word with the correct opcode but with bit 5 set must give no `out_valid` at all.

// File: rtl/vuw_pkg.sv
package vuw_pkg;

  typedef enum logic {
    GRP_PAIR = 1'b0,
    GRP_QUAD = 1'b1
  } grp_e;

  localparam logic [7:0]  OPC_TOP  = 8'hC1;
  localparam logic [11:0] OPC_PAIR = 12'b100101111000;
  localparam logic [11:0] OPC_QUAD = 12'b110101111000;

  // Write-enable pattern for a decoded, non-reserved word.
  function automatic logic [3:0] grp_mask(grp_e g);
    return (g == GRP_QUAD) ? 4'b1111 : 4'b0011;
  endfunction

  // Widen a half-width piece into a full element.
  function automatic logic [63:0] widen64(logic [31:0] piece, int unsigned hw, logic zx);
    logic [63:0] r;
    logic        sgn;
    sgn = piece[hw-1] & ~zx;
    for (int b = 0; b < 64; b++) begin
      r[b] = (b < int'(hw)) ? piece[b] : sgn;
    end
    return r;
  endfunction

endpackage

// File: rtl/vuw_decode.sv
module vuw_decode
  import vuw_pkg::*;
(
  input  logic [31:0] instr,
  output logic        hit,
  output grp_e        grp,
  output logic [1:0]  size,
  output logic        zero_ext,
  output logic [4:0]  dst_base,
  output logic [4:0]  src_idx0,
  output logic [4:0]  src_idx1
);

  logic top_ok, pair_ok, quad_ok;

  always_comb begin
    top_ok   = (instr[31:24] == OPC_TOP);
    pair_ok  = top_ok && (instr[21:10] == OPC_PAIR);
    quad_ok  = top_ok && (instr[21:10] == OPC_QUAD) && !instr[5] && !instr[1];
    hit      = pair_ok || quad_ok;
    grp      = quad_ok ? GRP_QUAD : GRP_PAIR;
    size     = instr[23:22];
    zero_ext = instr[0];
    if (quad_ok) begin
      dst_base = {instr[4:2], 2'b00};
      src_idx0 = {instr[9:6], 1'b0};
      src_idx1 = {instr[9:6], 1'b1};
    end else begin
      dst_base = {instr[4:1], 1'b0};
      src_idx0 = instr[9:5];
      src_idx1 = 5'd0;
    end
  end

endmodule

// File: rtl/vuw_lane_widen.sv
module vuw_lane_widen
  import vuw_pkg::*;
#(
  parameter int VL   = 128,
  parameter int HALF = 0
) (
  input  logic [VL-1:0] src,
  input  logic [1:0]    size,
  input  logic          zero_ext,
  output logic [VL-1:0] res
);

  logic [VL-1:0] cand [1:3];

  for (genvar s = 1; s < 4; s++) begin : g_sz
    localparam int DW = 8 << s;
    localparam int HW = DW / 2;
    localparam int NE = VL / DW;
    for (genvar e = 0; e < NE; e++) begin : g_el
      logic [HW-1:0] piece;
      logic [63:0]   wide;
      assign piece = src[(HALF*NE + e)*HW +: HW];
      assign wide  = widen64(32'(piece), HW, zero_ext);
      assign cand[s][e*DW +: DW] = wide[DW-1:0];
    end
  end

  always_comb begin
    case (size)
      2'd1:    res = cand[1];
      2'd2:    res = cand[2];
      2'd3:    res = cand[3];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/vec_unpack_widen.sv
module vec_unpack_widen
  import vuw_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [VL-1:0] src0,
  input  logic [VL-1:0] src1,
  output logic [4:0]    src_idx0,
  output logic [4:0]    src_idx1,
  output logic          out_valid,
  output logic          out_undef,
  output logic [3:0]    out_we,
  output logic [4:0]    out_idx0,
  output logic [4:0]    out_idx1,
  output logic [4:0]    out_idx2,
  output logic [4:0]    out_idx3,
  output logic [VL-1:0] out_d0,
  output logic [VL-1:0] out_d1,
  output logic [VL-1:0] out_d2,
  output logic [VL-1:0] out_d3
);

  localparam int NDST = 4;

  logic       dec_hit, dec_zx;
  grp_e       dec_grp;
  logic [1:0] dec_size;
  logic [4:0] dec_base;

  vuw_decode u_dec (
    .instr    (instr),
    .hit      (dec_hit),
    .grp      (dec_grp),
    .size     (dec_size),
    .zero_ext (dec_zx),
    .dst_base (dec_base),
    .src_idx0 (src_idx0),
    .src_idx1 (src_idx1)
  );

  // Named events for assertions.
  logic       accept, reserved_hit;
  logic [3:0] we_next;

  assign accept       = in_valid && dec_hit;
  assign reserved_hit = accept && (dec_size == 2'd0);
  assign we_next      = (accept && !reserved_hit) ? grp_mask(dec_grp) : 4'b0000;

  logic [VL-1:0] lane_res [NDST];
  logic [VL-1:0] d_q      [NDST];
  logic [4:0]    idx_q    [NDST];

  for (genvar k = 0; k < NDST; k++) begin : g_dst
    vuw_lane_widen #(.VL(VL), .HALF(k % 2)) u_lane (
      .src      ((k < 2) ? src0 : src1),
      .size     (dec_size),
      .zero_ext (dec_zx),
      .res      (lane_res[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        d_q[k]   <= '0;
        idx_q[k] <= '0;
      end else begin
        d_q[k]   <= we_next[k] ? lane_res[k] : '0;
        idx_q[k] <= we_next[k] ? (dec_base + 5'(k)) : 5'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_we    <= 4'b0000;
    end else begin
      out_valid <= accept;
      out_undef <= reserved_hit;
      out_we    <= we_next;
    end
  end

  assign out_d0   = d_q[0];
  assign out_d1   = d_q[1];
  assign out_d2   = d_q[2];
  assign out_d3   = d_q[3];
  assign out_idx0 = idx_q[0];
  assign out_idx1 = idx_q[1];
  assign out_idx2 = idx_q[2];
  assign out_idx3 = idx_q[3];

  assert_reserved_flag_R2: assert property (@(posedge clk) disable iff (rst)
    reserved_hit |=> (out_valid && out_undef && out_we == 4'b0000));

  assert_undef_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (out_we == 4'b0000 && out_d0 == '0 && out_d3 == '0));

  assert_we_shape_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_undef) |-> (out_we == 4'b0011 || out_we == 4'b1111));

  assert_nomatch_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_hit) |=> (!out_valid && out_we == 4'b0000));

  assert_pair_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (out_we == 4'b0011) |-> (out_d2 == '0 && out_d3 == '0 && out_idx2 == 5'd0));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_undef && out_we == 4'b0000));

  assert_consecutive_idx_R5: assert property (@(posedge clk) disable iff (rst)
    out_we[1] |-> (out_idx1 == out_idx0 + 5'd1));

endmodule

// File: tb/vec_unpack_widen_tb_top.sv
`timescale 1ns/1ps
module vec_unpack_widen_tb_top;

  localparam int VL = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VL-1:0] src0 = '0, src1 = '0;
  logic [4:0]    src_idx0, src_idx1;
  logic          out_valid, out_undef;
  logic [3:0]    out_we;
  logic [4:0]    out_idx0, out_idx1, out_idx2, out_idx3;
  logic [VL-1:0] out_d0, out_d1, out_d2, out_d3;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  vec_unpack_widen #(.VL(VL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src0(src0), .src1(src1), .src_idx0(src_idx0), .src_idx1(src_idx1),
    .out_valid(out_valid), .out_undef(out_undef), .out_we(out_we),
    .out_idx0(out_idx0), .out_idx1(out_idx1), .out_idx2(out_idx2), .out_idx3(out_idx3),
    .out_d0(out_d0), .out_d1(out_d1), .out_d2(out_d2), .out_d3(out_d3)
  );

  task automatic chk(input bit ok, input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected widening, computed bit by bit from R1, R3 and R7.
  function automatic logic [VL-1:0] model(logic [VL-1:0] s, int half, int sz, bit zx);
    int esz = 8 << sz;
    int hs  = esz / 2;
    int ne  = VL / esz;
    logic [VL-1:0] o = '0;
    for (int e = 0; e < ne; e++) begin
      for (int b = 0; b < esz; b++) begin
        int base = (half*ne + e) * hs;
        o[e*esz + b] = (b < hs) ? s[base + b] : (zx ? 1'b0 : s[base + hs - 1]);
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] mk_pair(logic [1:0] sz, logic [4:0] zn, logic [3:0] zd, logic u);
    return {8'hC1, sz, 12'b100101111000, zn, zd, u};
  endfunction

  function automatic logic [31:0] mk_quad(logic [1:0] sz, logic [3:0] zn, logic [2:0] zd, logic u);
    return {8'hC1, sz, 12'b110101111000, zn, 1'b0, zd, 1'b0, u};
  endfunction

  // Drive one word at a falling edge; outputs are sampled at the next falling edge.
  task automatic issue(input logic [31:0] w, input logic [VL-1:0] a, input logic [VL-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src0 = a; src1 = b;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0 && out_we === 4'b0000 && out_undef === 1'b0, "R10 reset",
        VL'({out_valid, out_undef, out_we}), '0);
  endtask

  task automatic t_pair(input int sz, input bit zx, input logic [4:0] zn, input logic [3:0] zd,
                        input logic [VL-1:0] a);
    logic [4:0] base = {zd, 1'b0};
    issue(mk_pair(2'(sz), zn, zd, zx), a, ~a);
    chk(src_idx0 == zn && src_idx1 == 5'd0, "R5 src index", VL'({src_idx0, src_idx1}), VL'({zn, 5'd0}));
    settle();
    chk(out_valid && !out_undef && out_we == 4'b0011, "R3 pair enables", VL'(out_we), VL'(4'b0011));
    chk(out_d0 == model(a, 0, sz, zx), "R3 R1 R7 pair low half", out_d0, model(a, 0, sz, zx));
    chk(out_d1 == model(a, 1, sz, zx), "R3 R1 R7 pair high half", out_d1, model(a, 1, sz, zx));
    chk(out_idx0 == base && out_idx1 == base + 5'd1, "R5 dest index",
        VL'({out_idx0, out_idx1}), VL'({base, base + 5'd1}));
    chk(out_d2 == '0 && out_d3 == '0 && out_idx2 == 0 && out_idx3 == 0, "R9 unused zero",
        out_d2 | out_d3, '0);
    @(negedge clk);
    chk(!out_valid && out_we == 4'b0000, "R10 idle after one", VL'({out_valid, out_we}), '0);
  endtask

  task automatic t_quad(input int sz, input bit zx, input logic [3:0] zn, input logic [2:0] zd,
                        input logic [VL-1:0] a, input logic [VL-1:0] b);
    logic [4:0] base = {zd, 2'b00};
    issue(mk_quad(2'(sz), zn, zd, zx), a, b);
    chk(src_idx0 == {zn, 1'b0} && src_idx1 == {zn, 1'b1}, "R6 src index",
        VL'({src_idx0, src_idx1}), VL'({zn, 1'b0, zn, 1'b1}));
    settle();
    chk(out_valid && out_we == 4'b1111, "R4 quad enables", VL'(out_we), VL'(4'b1111));
    chk(out_d0 == model(a, 0, sz, zx), "R4 R7 dest0", out_d0, model(a, 0, sz, zx));
    chk(out_d1 == model(a, 1, sz, zx), "R4 R7 dest1", out_d1, model(a, 1, sz, zx));
    chk(out_d2 == model(b, 0, sz, zx), "R4 R7 dest2", out_d2, model(b, 0, sz, zx));
    chk(out_d3 == model(b, 1, sz, zx), "R4 R7 dest3", out_d3, model(b, 1, sz, zx));
    chk(out_idx0 == base && out_idx1 == base + 1 && out_idx2 == base + 2 && out_idx3 == base + 3,
        "R6 dest index", VL'({out_idx0, out_idx3}), VL'({base, base + 5'd3}));
  endtask

  task automatic t_reserved_quad();
    issue(mk_quad(2'd0, 4'd3, 3'd2, 1'b0), {4{32'hDEADBEEF}}, {4{32'h80808080}});
    settle();
    chk(out_valid && out_undef && out_we == 4'b0000, "R2 reserved size flag",
        VL'({out_valid, out_undef, out_we}), VL'(6'b110000));
    chk(out_d0 == '0 && out_d1 == '0 && out_d2 == '0 && out_d3 == '0, "R2 reserved no data",
        out_d0 | out_d1 | out_d2 | out_d3, '0);
  endtask

  task automatic t_nomatch();
    logic [31:0] w;
    w = mk_pair(2'd1, 5'd1, 4'd1, 1'b0); w[31:24] = 8'hC2;
    issue(w, '1, '1); settle();
    chk(!out_valid && out_we == 0, "R8 wrong top byte", VL'({out_valid, out_we}), '0);
    w = mk_quad(2'd2, 4'd1, 3'd1, 1'b0); w[5] = 1'b1;
    issue(w, '1, '1); settle();
    chk(!out_valid && out_we == 0, "R8 quad bit5 set", VL'({out_valid, out_we}), '0);
    w = mk_quad(2'd2, 4'd1, 3'd1, 1'b0); w[1] = 1'b1;
    issue(w, '1, '1); settle();
    chk(!out_valid && out_we == 0, "R8 quad bit1 set", VL'({out_valid, out_we}), '0);
    w = mk_pair(2'd1, 5'd1, 4'd1, 1'b0); w[15] = ~w[15];
    issue(w, '1, '1); settle();
    chk(!out_valid && out_we == 0, "R8 wrong middle field", VL'({out_valid, out_we}), '0);
  endtask

  task automatic t_midreset();
    issue(mk_pair(2'd1, 5'd2, 4'd2, 1'b0), '1, '0);
    rst = 1'b1;
    settle();
    rst = 1'b0;
    chk(!out_valid && out_we == 0 && out_d0 == '0, "R10 sync reset clears", out_d0, '0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pair(1, 1'b0, 5'd17, 4'd9, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F);
    t_pair(2, 1'b1, 5'd31, 4'd15, 128'h80000001_7FFFFFFE_C0DEBEEF_01234567);
    t_pair(3, 1'b0, 5'd0, 4'd0, 128'h89ABCDEF_00000000_80000000_7FFFFFFF);
    t_quad(3, 1'b0, 4'd7, 3'd5, 128'hFEDCBA98_76543210_80000000_00000001,
           128'h12345678_9ABCDEF0_FFFFFFFF_7FFFFFFF);
    t_quad(1, 1'b1, 4'd15, 3'd7, 128'h8081_7F7E_FF00_00FF_A5A5_5A5A_C3C3_3C3C,
           128'h0102_0304_8899_AABB_CCDD_EEFF_1122_3344);
    t_quad(2, 1'b0, 4'd0, 3'd0, 128'h8000_7FFF_FFFF_0001_8001_0080_FF7F_1234,
           128'hA0B0_C0D0_0E0F_1011_F00D_CAFE_8888_7777);
    t_reserved_quad();
    t_nomatch();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule